// File: doc/BRIEF.md
# Programmed-IO Byte FIFO Register

This block is the data port that a host uses when a SCSI-style controller runs a command without DMA. The host reaches it through one slot in a small byte register window. Each write to that slot pushes a byte into an on-chip store. Each read takes a byte out, lowers the byte count and sends an interrupt pulse. The command engine can also reload the FIFO. A reload loads a 16-bit transfer count from two byte-wide count registers and sets both pointers back to the start of the store. The host then reads that many bytes from slot zero onward.

The pointers do not wrap around the store. The read pointer and the write pointer both go back to zero when a read leaves the count at zero, and again on every reload. Each pointer therefore always counts from the start of the store. The write pointer marks "full" when it reaches the store depth. Writes made after that point are dropped and raise an overflow flag that stays set.

Top module: `pio_fifo`

## Requirements
- R1: After reset, count_o is 0, irq_o is 0, ovf_o is 0 and rdata_o is 0x00.
- R2: The data register is at register index 2, where the index is byte-address bits [5:2] (byte address 0x08). Strobes at any other index leave count_o, rdata_o, irq_o and ovf_o unchanged.
- R3: A write strobe at the data register stores wdata_i at the write pointer. From the next cycle, count_o is one higher.
- R4: A read strobe at the data register while count_o is nonzero loads rdata_o with the byte at the read pointer from the next cycle and lowers count_o by one. Bytes come out in the order they were written.
- R5: Each successful pop makes irq_o high for exactly the one cycle that follows the read strobe. In every other cycle irq_o is low.
- R6: A read strobe while count_o is 0, with no write in the same cycle, leaves rdata_o at its previous value, leaves count_o at 0 and gives no irq_o pulse.
- R7: When a read leaves the count at zero, both pointers return to slot 0. After such a drain, a further DEPTH writes are accepted without overflow.
- R8: reload_i loads count_o with cnt_hi_i*256 + cnt_lo_i in the next cycle and sets both pointers to slot 0, so later reads return the bytes stored from slot 0 onward. A bus strobe in the same cycle as reload_i has no effect.
- R9: A write made after DEPTH writes since the last pointer rewind is dropped and leaves count_o unchanged. It sets ovf_o, which stays 1 until reset.
- R10: A read and a write to the data register in the same cycle act as the write first, then the read. When the FIFO is empty, rdata_o returns the byte just written, count_o stays 0 and irq_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 6 | Register-window byte address |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| wdata_i | input | 8 | Host write data |
| reload_i | input | 1 | Non-DMA reload request from the command engine |
| cnt_lo_i | input | 8 | Transfer count, low byte |
| cnt_hi_i | input | 8 | Transfer count, high byte |
| rdata_o | output | 8 | Last popped byte |
| count_o | output | 17 | Current byte count |
| irq_o | output | 1 | Interrupt pulse, one per pop |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The pointer rewind is the hardest behaviour to observe, because the pointers are not visible at the ports. The test drains a partly filled FIFO and then writes exactly DEPTH more bytes. The overflow flag stays clear only if the write pointer went back to slot 0. The same filled store is then used after a reload with a short count: reads must return the bytes in slots 0, 1 and 2, which shows that the read pointer was also rewound.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;

    // Register index width inside the byte-addressed window (addr[5:2]).
    localparam int REG_IDX_W    = 4;
    localparam int DATA_REG_IDX = 2;
    localparam int BYTE_W       = 8;
    localparam int XFER_W       = 16;

    // Kind of host access to the data register in one cycle.
    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_WR   = 2'b01,
        ACC_RD   = 2'b10,
        ACC_RW   = 2'b11
    } acc_e;

endpackage

// File: rtl/pio_fifo_decode.sv
module pio_fifo_decode
    import pio_fifo_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output acc_e              acc_o
);

    localparam int IDX_LSB = 2;

    logic [REG_IDX_W-1:0] reg_idx;
    logic                 hit;
    logic [1:0]           unused_low;

    assign reg_idx    = addr_i[IDX_LSB +: REG_IDX_W];
    assign unused_low = addr_i[IDX_LSB-1:0];
    assign hit        = (reg_idx == REG_IDX_W'(DATA_REG_IDX));

    always_comb begin
        acc_o = ACC_NONE;
        if (hit) begin
            unique case ({rd_i, wr_i})
                2'b01:   acc_o = ACC_WR;
                2'b10:   acc_o = ACC_RD;
                2'b11:   acc_o = ACC_RW;
                default: acc_o = ACC_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pio_fifo_store.sv
module pio_fifo_store #(
    parameter int DEPTH_LOG2 = 8,
    parameter int DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  we_i,
    input  logic [DEPTH_LOG2-1:0] waddr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [DEPTH_LOG2-1:0] raddr_i,
    output logic [DATA_W-1:0]     rdata_o
);

    localparam int DEPTH = 1 << DEPTH_LOG2;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
    import pio_fifo_pkg::*;
#(
    parameter int DEPTH_LOG2 = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  acc_e                  acc_i,
    input  logic [BYTE_W-1:0]     wdata_i,
    input  logic                  reload_i,
    input  logic [BYTE_W-1:0]     cnt_lo_i,
    input  logic [BYTE_W-1:0]     cnt_hi_i,
    output logic                  mem_we_o,
    output logic [DEPTH_LOG2-1:0] mem_waddr_o,
    output logic [BYTE_W-1:0]     mem_wdata_o,
    output logic [DEPTH_LOG2-1:0] mem_raddr_o,
    input  logic [BYTE_W-1:0]     mem_rdata_i,
    output logic [XFER_W:0]       count_o,
    output logic [BYTE_W-1:0]     rdata_o,
    output logic                  irq_o,
    output logic                  ovf_o
);

    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int PTR_W = DEPTH_LOG2 + 1;
    localparam int CNT_W = XFER_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0]  rptr;
        logic [PTR_W-1:0]  wptr;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rdata;
        logic              irq;
        logic              ovf;
    } st_t;

    st_t st_q, st_d;

    logic              wr_hit, rd_hit, full, we, bypass;
    logic [BYTE_W-1:0] pop_byte;

    assign wr_hit = (acc_i == ACC_WR) || (acc_i == ACC_RW);
    assign rd_hit = (acc_i == ACC_RD) || (acc_i == ACC_RW);
    assign full   = (st_q.wptr == PTR_W'(DEPTH));
    assign bypass = we && (st_q.rptr[DEPTH_LOG2-1:0] == st_q.wptr[DEPTH_LOG2-1:0]);
    assign pop_byte = bypass ? wdata_i : mem_rdata_i;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        we       = 1'b0;
        if (reload_i) begin
            st_d.cnt  = CNT_W'({cnt_hi_i, cnt_lo_i});
            st_d.rptr = '0;
            st_d.wptr = '0;
        end else begin
            // Write is applied first.
            if (wr_hit) begin
                if (full) begin
                    st_d.ovf = 1'b1;
                end else begin
                    we        = 1'b1;
                    st_d.wptr = st_q.wptr + PTR_W'(1);
                    st_d.cnt  = st_q.cnt + CNT_W'(1);
                end
            end
            // Then the read, against the count after the write.
            if (rd_hit) begin
                if (st_d.cnt != '0) begin
                    st_d.rdata = pop_byte;
                    st_d.rptr  = st_q.rptr + PTR_W'(1);
                    st_d.cnt   = st_d.cnt - CNT_W'(1);
                    st_d.irq   = 1'b1;
                end
                if (st_d.cnt == '0) begin
                    st_d.rptr = '0;
                    st_d.wptr = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we_o    = we;
    assign mem_waddr_o = st_q.wptr[DEPTH_LOG2-1:0];
    assign mem_wdata_o = wdata_i;
    assign mem_raddr_o = st_q.rptr[DEPTH_LOG2-1:0];
    assign count_o     = st_q.cnt;
    assign rdata_o     = st_q.rdata;
    assign irq_o       = st_q.irq;
    assign ovf_o       = st_q.ovf;

    a_r3_push_count: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !rd_hit && !reload_i && !full) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    a_r5_irq_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !reload_i && st_q.cnt != '0) |=> st_q.irq);

    a_r6_empty_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !wr_hit && !reload_i && st_q.cnt == '0) |=> (!st_q.irq && $stable(st_q.rdata)));

    a_r7_rewind_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !wr_hit && !reload_i && st_q.cnt <= CNT_W'(1)) |=> (st_q.rptr == '0 && st_q.wptr == '0));

    a_r8_reload_count: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (st_q.cnt == CNT_W'({$past(cnt_hi_i), $past(cnt_lo_i)})));

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);

    a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !rd_hit && !reload_i && full) |=> ($stable(st_q.cnt) && st_q.ovf));

endmodule

// File: rtl/pio_fifo.sv
module pio_fifo
    import pio_fifo_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DEPTH_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [7:0]        wdata_i,
    input  logic              reload_i,
    input  logic [7:0]        cnt_lo_i,
    input  logic [7:0]        cnt_hi_i,
    output logic [7:0]        rdata_o,
    output logic [16:0]       count_o,
    output logic              irq_o,
    output logic              ovf_o
);

    acc_e                  acc;
    logic                  mem_we;
    logic [DEPTH_LOG2-1:0] mem_waddr, mem_raddr;
    logic [BYTE_W-1:0]     mem_wdata, mem_rdata;

    pio_fifo_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (addr_i),
        .wr_i   (wr_i),
        .rd_i   (rd_i),
        .acc_o  (acc)
    );

    pio_fifo_store #(.DEPTH_LOG2(DEPTH_LOG2), .DATA_W(BYTE_W)) u_store (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

    pio_fifo_ctrl #(.DEPTH_LOG2(DEPTH_LOG2)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_i       (acc),
        .wdata_i     (wdata_i),
        .reload_i    (reload_i),
        .cnt_lo_i    (cnt_lo_i),
        .cnt_hi_i    (cnt_hi_i),
        .mem_we_o    (mem_we),
        .mem_waddr_o (mem_waddr),
        .mem_wdata_o (mem_wdata),
        .mem_raddr_o (mem_raddr),
        .mem_rdata_i (mem_rdata),
        .count_o     (count_o),
        .rdata_o     (rdata_o),
        .irq_o       (irq_o),
        .ovf_o       (ovf_o)
    );

endmodule

// File: tb/pio_fifo_tb_top.sv
module pio_fifo_tb_top;

    localparam int DEPTH = 256;
    localparam logic [5:0] DATA_ADDR  = 6'h08;
    localparam logic [5:0] OTHER_ADDR = 6'h0C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  addr;
    logic        wr, rd, reload;
    logic [7:0]  wdata, cnt_lo, cnt_hi;
    logic [7:0]  rdata;
    logic [16:0] count;
    logic        irq, ovf;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    pio_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
        .wdata_i(wdata), .reload_i(reload), .cnt_lo_i(cnt_lo), .cnt_hi_i(cnt_hi),
        .rdata_o(rdata), .count_o(count), .irq_o(irq), .ovf_o(ovf)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr = 0; rd = 0; reload = 0;
        addr = '0; wdata = '0; cnt_lo = '0; cnt_hi = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus(logic [5:0] a, logic w, logic r, logic [7:0] d);
        @(negedge clk);
        addr = a; wr = w; rd = r; wdata = d;
        @(negedge clk);
        wr = 0; rd = 0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        idle();
        check("R1", "count", int'(count), 0);
        check("R1", "irq", int'(irq), 0);
        check("R1", "ovf", int'(ovf), 0);
        check("R1", "rdata", int'(rdata), 0);
    endtask

    task automatic t_empty_read();
        bus(DATA_ADDR, 0, 1, 8'h00);
        check("R6", "rdata empty read", int'(rdata), 0);
        check("R6", "irq empty read", int'(irq), 0);
        check("R6", "count empty read", int'(count), 0);
    endtask

    task automatic t_other_index();
        bus(OTHER_ADDR, 1, 0, 8'hAA);
        check("R2", "count after other-index write", int'(count), 0);
        bus(DATA_ADDR, 1, 0, 8'h5C);
        bus(OTHER_ADDR, 0, 1, 8'h00);
        check("R2", "count after other-index read", int'(count), 1);
        check("R2", "irq after other-index read", int'(irq), 0);
        bus(DATA_ADDR, 0, 1, 8'h00);
        check("R2", "pop after other-index", int'(rdata), 8'h5C);
    endtask

    task automatic t_order();
        bus(DATA_ADDR, 1, 0, 8'h11);
        check("R3", "count after 1 write", int'(count), 1);
        bus(DATA_ADDR, 1, 0, 8'h22);
        bus(DATA_ADDR, 1, 0, 8'h33);
        check("R3", "count after 3 writes", int'(count), 3);
        bus(DATA_ADDR, 0, 1, 8'h00);
        check("R4", "first pop", int'(rdata), 8'h11);
        check("R4", "count after pop", int'(count), 2);
        check("R5", "irq pulse high", int'(irq), 1);
        idle();
        check("R5", "irq pulse low after", int'(irq), 0);
        bus(DATA_ADDR, 0, 1, 8'h00);
        check("R4", "second pop", int'(rdata), 8'h22);
        bus(DATA_ADDR, 0, 1, 8'h00);
        check("R4", "third pop", int'(rdata), 8'h33);
        check("R4", "count drained", int'(count), 0);
        bus(DATA_ADDR, 0, 1, 8'h00);
        check("R6", "rdata held after drain", int'(rdata), 8'h33);
        check("R6", "no irq after drain", int'(irq), 0);
    endtask

    task automatic t_rewind_full_reload();
        // R7: partial fill then drain must rewind the write pointer.
        for (int i = 0; i < 3; i++) bus(DATA_ADDR, 1, 0, 8'hF0);
        for (int i = 0; i < 3; i++) bus(DATA_ADDR, 0, 1, 8'h00);
        for (int i = 0; i < DEPTH; i++) bus(DATA_ADDR, 1, 0, pat(i));
        check("R7", "count after DEPTH writes", int'(count), DEPTH);
        check("R7", "no overflow after rewind", int'(ovf), 0);
        // R9: one more write is dropped.
        bus(DATA_ADDR, 1, 0, 8'hEE);
        check("R9", "count unchanged when full", int'(count), DEPTH);
        check("R9", "ovf set", int'(ovf), 1);
        // R8: reload with a simultaneous bus write that must be ignored.
        @(negedge clk);
        reload = 1; cnt_lo = 8'd3; cnt_hi = 8'd0;
        addr = DATA_ADDR; wr = 1; wdata = 8'h99;
        @(negedge clk);
        reload = 0; wr = 0;
        check("R8", "reload count", int'(count), 3);
        for (int i = 0; i < 3; i++) begin
            bus(DATA_ADDR, 0, 1, 8'h00);
            check("R8", "byte from slot after reload", int'(rdata), int'(pat(i)));
        end
        check("R8", "count after reload reads", int'(count), 0);
        check("R9", "ovf sticky", int'(ovf), 1);
        // R8: count byte order.
        @(negedge clk);
        reload = 1; cnt_lo = 8'h34; cnt_hi = 8'h12;
        @(negedge clk);
        reload = 0;
        check("R8", "reload hi/lo", int'(count), 16'h1234);
    endtask

    task automatic t_simultaneous();
        bus(DATA_ADDR, 1, 1, 8'h77);
        check("R10", "bypass byte on empty", int'(rdata), 8'h77);
        check("R10", "count stays 0", int'(count), 0);
        check("R10", "irq on bypass pop", int'(irq), 1);
        bus(DATA_ADDR, 1, 0, 8'h41);
        bus(DATA_ADDR, 1, 1, 8'h42);
        check("R10", "rw pops older byte", int'(rdata), 8'h41);
        check("R10", "rw count net", int'(count), 1);
        bus(DATA_ADDR, 0, 1, 8'h00);
        check("R10", "queued byte after rw", int'(rdata), 8'h42);
    endtask

    initial begin
        rst_n = 1'b0; wr = 0; rd = 0; reload = 0;
        addr = '0; wdata = '0; cnt_lo = '0; cnt_hi = '0;
        t_reset();
        t_empty_read();
        t_other_index();
        t_order();
        t_rewind_full_reload();
        t_reset();
        t_simultaneous();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule